// File: doc/BRIEF.md
# Program Counter Rotation and Branch Unit

This block holds the instruction address of a small 4-bit processor. It keeps four 12-bit address counters. A 2-bit level selector picks one of them as the live counter, and that counter drives the address output. The selector wraps, so there is no stack in memory: a subroutine call moves the selector up one step and loads the newly selected counter. A return moves the selector down one step and leaves the earlier counter exactly as it was. This gives three nested call levels above the base level.

The instruction decoder drives one strobe per cycle. The strobes are: advance by one, absolute jump, call, return, conditional in-page jump, increment-and-skip in-page jump, and indirect in-page jump. It also supplies the operands: a 12-bit target, an 8-bit in-page target or register-pair value, a 4-bit condition code, and the accumulator-zero, carry, TST level and register-nonzero flags. The decoder is expected to have already advanced the counter past a two-byte instruction before it raises an in-page strobe. The page bits are therefore taken from the live counter's current value. All interfaces are plain control pins with no handshake, and every strobe acts at the next rising clock edge.

Top module: `pcsb_top`

## Requirements
- R1: While rst_n is low, all four counters and the level selector are cleared. After reset, pc_addr reads 0x000, and a return from level 0 also shows 0x000.
- R2: step_en adds 1 to the live counter modulo 4096, so 0xFFF becomes 0x000. The level selector does not change.
- R3: jump_en loads the live counter with jmp_target.
- R4: call_en first moves the selector up by one, then loads the newly selected counter with jmp_target. The counter that was live before the call is not modified.
- R5: ret_en moves the selector down by one and writes no counter. pc_addr then shows the value the caller's counter already held.
- R6: The selector wraps modulo 4 in both directions. A fourth nested call overwrites the base-level counter, and a return from level 0 selects level 3.
- R7: cjump_en with cond_code[3]=0 takes the jump when any enabled test is true. The tests are: bit 0 enables "tst_level is 0", bit 1 enables "carry is 1", and bit 2 enables "acc_zero is 1". A code of 0000 never jumps.
- R8: cjump_en with cond_code[3]=1 takes the jump only when none of the enabled tests is true. A code of 1000 always jumps.
- R9: A taken in-page jump writes page_addr into bits 7:0 of the live counter and keeps bits 11:8 of its current value. A jump that is not taken leaves the counter unchanged.
- R10: ijump_en always replaces bits 7:0 of the live counter with page_addr and keeps bits 11:8.
- R11: skip_en takes the in-page jump when skip_nz is 1. When skip_nz is 0 it leaves the counter unchanged, so execution falls through.
- R12: When several strobes are high in the same cycle, only the first in this order acts and the others are ignored: call_en, ret_en, jump_en, cjump_en, skip_en, ijump_en, step_en. With no strobe high, pc_addr holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance live counter by one |
| jump_en | input | 1 | Absolute jump to jmp_target |
| call_en | input | 1 | Subroutine call to jmp_target |
| ret_en | input | 1 | Return to the previous level |
| cjump_en | input | 1 | Conditional in-page jump |
| skip_en | input | 1 | Increment-and-skip in-page jump |
| ijump_en | input | 1 | Indirect in-page jump |
| jmp_target | input | 12 | Full target for jump and call |
| page_addr | input | 8 | In-page target or register-pair value |
| cond_code | input | 4 | Condition code: bit 3 inverts, bits 2:0 enable the tests |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| tst_level | input | 1 | Level of the TST pin |
| skip_nz | input | 1 | Incremented register is nonzero |
| pc_addr | output | 12 | Live counter value |

## Verification
The hardest cases to reach from the ports are the wrap of the level selector and the proof that a hidden counter was left untouched. A counter that is not live cannot be seen until a return brings it back. The stimulus therefore nests four calls so that the base-level counter is overwritten, then returns past level 0. It also returns from level 0 straight after reset. The condition logic is swept over all 16 codes against all 8 flag combinations from a known page. A long pseudo-random phase then raises several strobes at once so that the priority order is exercised against the reference model.

// File: rtl/pcsb_pkg.sv
package pcsb_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JABS = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_COND = 3'd5,
    OP_SKIP = 3'd6,
    OP_IND  = 3'd7
  } pcsb_op_e;

  localparam int TEST_W = 3;

endpackage

// File: rtl/pcsb_arb.sv
module pcsb_arb
  import pcsb_pkg::*;
(
  input  logic     step_en,
  input  logic     jump_en,
  input  logic     call_en,
  input  logic     ret_en,
  input  logic     cjump_en,
  input  logic     skip_en,
  input  logic     ijump_en,
  output pcsb_op_e op
);

  // Fixed priority: level changes first, then full jumps, then in-page, then step.
  always_comb begin
    if (call_en)       op = OP_CALL;
    else if (ret_en)   op = OP_RET;
    else if (jump_en)  op = OP_JABS;
    else if (cjump_en) op = OP_COND;
    else if (skip_en)  op = OP_SKIP;
    else if (ijump_en) op = OP_IND;
    else if (step_en)  op = OP_STEP;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/pcsb_cond.sv
module pcsb_cond
  import pcsb_pkg::*;
(
  input  logic [TEST_W:0] cond_code,
  input  logic            acc_zero,
  input  logic            carry,
  input  logic            tst_level,
  output logic            take
);

  logic [TEST_W-1:0] test_true;
  logic              any_hit;

  // Bit order of the tests matches the enable bits of the code.
  assign test_true = {acc_zero, carry, ~tst_level};
  assign any_hit   = |(cond_code[TEST_W-1:0] & test_true);
  assign take      = cond_code[TEST_W] ? ~any_hit : any_hit;

endmodule

// File: rtl/pcsb_sel.sv
module pcsb_sel
  import pcsb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcsb_op_e         op,
  output logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] sel_up
);

  logic [SEL_W-1:0] sel_dn;

  assign sel_up = (sel_q == SEL_W'(DEPTH - 1)) ? '0 : sel_q + SEL_W'(1);
  assign sel_dn = (sel_q == '0) ? SEL_W'(DEPTH - 1) : sel_q - SEL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)              sel_q <= '0;
    else if (op == OP_CALL)  sel_q <= sel_up;
    else if (op == OP_RET)   sel_q <= sel_dn;
  end

endmodule

// File: rtl/pcsb_bank.sv
module pcsb_bank #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int SEL_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_val,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_val
);

  logic [ADDR_W-1:0] ctr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en && wr_idx == SEL_W'(g))   q <= wr_val;
    end
    assign ctr[g] = q;
  end

  assign rd_val = ctr[rd_idx];

endmodule

// File: rtl/pcsb_top.sv
module pcsb_top
  import pcsb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              jump_en,
  input  logic              call_en,
  input  logic              ret_en,
  input  logic              cjump_en,
  input  logic              skip_en,
  input  logic              ijump_en,
  input  logic [ADDR_W-1:0] jmp_target,
  input  logic [LOW_W-1:0]  page_addr,
  input  logic [TEST_W:0]   cond_code,
  input  logic              acc_zero,
  input  logic              carry,
  input  logic              tst_level,
  input  logic              skip_nz,
  output logic [ADDR_W-1:0] pc_addr
);

  localparam int SEL_W  = $clog2(DEPTH);
  localparam int PAGE_W = ADDR_W - LOW_W;

  pcsb_op_e          op;
  logic              cond_take;
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_up;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_val;
  logic [ADDR_W-1:0] live_pc;
  logic [ADDR_W-1:0] in_page;

  pcsb_arb u_arb (
    .step_en  (step_en),
    .jump_en  (jump_en),
    .call_en  (call_en),
    .ret_en   (ret_en),
    .cjump_en (cjump_en),
    .skip_en  (skip_en),
    .ijump_en (ijump_en),
    .op       (op)
  );

  pcsb_cond u_cond (
    .cond_code (cond_code),
    .acc_zero  (acc_zero),
    .carry     (carry),
    .tst_level (tst_level),
    .take      (cond_take)
  );

  pcsb_sel #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .sel_q  (sel_q),
    .sel_up (sel_up)
  );

  // Page bits come from the live counter, already advanced by the decoder.
  assign in_page = {live_pc[ADDR_W-1 -: PAGE_W], page_addr};

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = sel_q;
    wr_val = live_pc;
    unique case (op)
      OP_STEP: begin wr_en = 1'b1;      wr_val = live_pc + ADDR_W'(1); end
      OP_JABS: begin wr_en = 1'b1;      wr_val = jmp_target;           end
      OP_CALL: begin wr_en = 1'b1;      wr_val = jmp_target; wr_idx = sel_up; end
      OP_COND: begin wr_en = cond_take; wr_val = in_page;              end
      OP_SKIP: begin wr_en = skip_nz;   wr_val = in_page;              end
      OP_IND:  begin wr_en = 1'b1;      wr_val = in_page;              end
      OP_RET, OP_HOLD: wr_en = 1'b0;
      default: wr_en = 1'b0;
    endcase
  end

  pcsb_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .rd_idx (sel_q),
    .rd_val (live_pc)
  );

  assign pc_addr = live_pc;

endmodule

// File: rtl/pcsb_chk.sv
module pcsb_chk #(
  parameter int ADDR_W = 12,
  parameter int LOW_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic              jump_en,
  input logic              call_en,
  input logic              ret_en,
  input logic              cjump_en,
  input logic              skip_en,
  input logic              ijump_en,
  input logic [ADDR_W-1:0] jmp_target,
  input logic [LOW_W-1:0]  page_addr,
  input logic [3:0]        cond_code,
  input logic              acc_zero,
  input logic              carry,
  input logic              tst_level,
  input logic              skip_nz,
  input logic [ADDR_W-1:0] pc_addr
);

  logic above_cond, cond_only, skip_only, ind_only, step_only, jabs_only, idle;

  assign above_cond = call_en | ret_en | jump_en;
  assign jabs_only  = jump_en & ~call_en & ~ret_en;
  assign cond_only  = cjump_en & ~above_cond;
  assign skip_only  = skip_en & ~cjump_en & ~above_cond;
  assign ind_only   = ijump_en & ~skip_en & ~cjump_en & ~above_cond;
  assign step_only  = step_en & ~ijump_en & ~skip_en & ~cjump_en & ~above_cond;
  assign idle       = ~(step_en | ijump_en | skip_en | cjump_en | above_cond);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_addr == '0);

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_only |=> pc_addr == $past(pc_addr) + ADDR_W'(1));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jabs_only |=> pc_addr == $past(jmp_target));

  // R4
  call_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_en |=> pc_addr == $past(jmp_target));

  // R7
  cond_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_only && !cond_code[3] && !(cond_code[0] && !tst_level)
      && !(cond_code[1] && carry) && !(cond_code[2] && acc_zero) |=> $stable(pc_addr));

  // R8
  cond_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_only && cond_code == 4'b1000 |=>
      pc_addr == {$past(pc_addr[ADDR_W-1:LOW_W]), $past(page_addr)});

  // R10
  ind_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ind_only |=> pc_addr == {$past(pc_addr[ADDR_W-1:LOW_W]), $past(page_addr)});

  // R11
  skip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_only && !skip_nz |=> $stable(pc_addr));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(pc_addr));

endmodule

bind pcsb_top pcsb_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .jump_en    (jump_en),
  .call_en    (call_en),
  .ret_en     (ret_en),
  .cjump_en   (cjump_en),
  .skip_en    (skip_en),
  .ijump_en   (ijump_en),
  .jmp_target (jmp_target),
  .page_addr  (page_addr),
  .cond_code  (cond_code),
  .acc_zero   (acc_zero),
  .carry      (carry),
  .tst_level  (tst_level),
  .skip_nz    (skip_nz),
  .pc_addr    (pc_addr)
);

// File: tb/test_pcsb_top.sv
`timescale 1ns/1ps
module test_pcsb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 0, jump_en = 0, call_en = 0, ret_en = 0;
  logic        cjump_en = 0, skip_en = 0, ijump_en = 0;
  logic [11:0] jmp_target = '0;
  logic [7:0]  page_addr = '0;
  logic [3:0]  cond_code = '0;
  logic        acc_zero = 0, carry = 0, tst_level = 1, skip_nz = 0;
  logic [11:0] pc_addr;

  int checks = 0;
  int fails  = 0;
  int ref_pc [4];
  int ref_sel = 0;

  always #2 clk = ~clk;

  pcsb_top i_pcsb_top (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en),
    .call_en(call_en), .ret_en(ret_en), .cjump_en(cjump_en), .skip_en(skip_en),
    .ijump_en(ijump_en), .jmp_target(jmp_target), .page_addr(page_addr),
    .cond_code(cond_code), .acc_zero(acc_zero), .carry(carry),
    .tst_level(tst_level), .skip_nz(skip_nz), .pc_addr(pc_addr)
  );

  function automatic void in_page_load(input int low);
    ref_pc[ref_sel] = (ref_pc[ref_sel] / 256) * 256 + low;
  endfunction

  // Reference model: applies one cycle of strobes to the behavioural state.
  function automatic void model_step();
    bit hit;
    bit go;
    if (call_en) begin
      ref_sel = (ref_sel + 1) % 4;
      ref_pc[ref_sel] = int'(jmp_target);
    end else if (ret_en) begin
      ref_sel = (ref_sel + 3) % 4;
    end else if (jump_en) begin
      ref_pc[ref_sel] = int'(jmp_target);
    end else if (cjump_en) begin
      hit = 0;
      if (cond_code[0] && tst_level == 0) hit = 1;
      if (cond_code[1] && carry == 1)     hit = 1;
      if (cond_code[2] && acc_zero == 1)  hit = 1;
      go = cond_code[3] ? !hit : hit;
      if (go) in_page_load(int'(page_addr));
    end else if (skip_en) begin
      if (skip_nz) in_page_load(int'(page_addr));
    end else if (ijump_en) begin
      in_page_load(int'(page_addr));
    end else if (step_en) begin
      ref_pc[ref_sel] = (ref_pc[ref_sel] + 1) % 4096;
    end
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (int'(pc_addr) != ref_pc[ref_sel]) begin
      fails++;
      $display("FAIL %s: pc_addr=%03h expected %03h", tag, pc_addr, ref_pc[ref_sel]);
    end
  endtask

  // Entered at a falling edge: drive, advance model, compare at next falling edge.
  task automatic cyc(input logic [6:0] stb, input logic [11:0] t12, input logic [7:0] t8,
                     input logic [3:0] cc, input logic [2:0] flags, input logic snz,
                     input string tag);
    {call_en, ret_en, jump_en, cjump_en, skip_en, ijump_en, step_en} = stb;
    jmp_target = t12; page_addr = t8; cond_code = cc;
    {acc_zero, carry, tst_level} = flags;
    skip_nz = snz;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [6:0] S_CALL = 7'b1000000, S_RET = 7'b0100000, S_JMP = 7'b0010000,
                         S_CND = 7'b0001000, S_SKP = 7'b0000100, S_IND = 7'b0000010,
                         S_STP = 7'b0000001, S_NONE = 7'b0;

  function automatic string tag_of(input logic [6:0] s);
    if ($countones(s) > 1) return "R12";
    case (s)
      S_CALL: return "R4";
      S_RET:  return "R5";
      S_JMP:  return "R3";
      S_CND:  return "R9";
      S_SKP:  return "R11";
      S_IND:  return "R10";
      S_STP:  return "R2";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) ref_pc[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    cyc(S_NONE, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R1");
    // R1: return from level 0 shows counter 3, cleared by reset
    cyc(S_RET, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R1");
    cyc(S_CALL, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R6");
    // R2 stepping and wrap at 0xFFF
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    cyc(S_JMP, 12'hFFE, 8'h00, 4'h0, 3'b001, 0, "R3");
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    // R4/R5 nested calls and returns
    cyc(S_JMP, 12'h100, 8'h00, 4'h0, 3'b001, 0, "R3");
    cyc(S_CALL, 12'h123, 8'h00, 4'h0, 3'b001, 0, "R4");
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    cyc(S_CALL, 12'h456, 8'h00, 4'h0, 3'b001, 0, "R4");
    cyc(S_CALL, 12'h789, 8'h00, 4'h0, 3'b001, 0, "R4");
    cyc(S_RET, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R5");
    cyc(S_RET, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R5");
    cyc(S_RET, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R5");
    // R6 fourth nested call overwrites the base counter
    for (int k = 0; k < 4; k++) cyc(S_CALL, 12'hA00 + 12'(k), 8'h00, 4'h0, 3'b001, 0, "R6");
    for (int k = 0; k < 5; k++) cyc(S_RET, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R6");
    // R7/R8 full sweep of codes and flags
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 8; f++) begin
        cyc(S_JMP, 12'h3A0, 8'h00, 4'h0, 3'b001, 0, "R3");
        cyc(S_CND, 12'h000, 8'h5C, 4'(c), 3'(f), 0, (c >= 8) ? "R8" : "R7");
      end
    end
    // R9 page taken from the advanced counter across a page edge
    cyc(S_JMP, 12'hAFF, 8'h00, 4'h0, 3'b001, 0, "R3");
    cyc(S_STP, 12'h000, 8'h00, 4'h0, 3'b001, 0, "R2");
    cyc(S_CND, 12'h000, 8'h11, 4'h8, 3'b001, 0, "R9");
    cyc(S_CND, 12'h000, 8'h22, 4'h0, 3'b001, 0, "R9");
    // R10 indirect, R11 skip both ways
    cyc(S_IND, 12'h000, 8'hE7, 4'h0, 3'b001, 0, "R10");
    cyc(S_SKP, 12'h000, 8'h40, 4'h0, 3'b001, 0, "R11");
    cyc(S_SKP, 12'h000, 8'h41, 4'h0, 3'b001, 1, "R11");
    // R12 simultaneous strobes
    cyc(S_CALL | S_RET | S_STP, 12'h5A5, 8'h00, 4'h0, 3'b001, 0, "R12");
    cyc(S_RET | S_JMP, 12'h777, 8'h00, 4'h0, 3'b001, 0, "R12");
    cyc(S_JMP | S_CND | S_STP, 12'h888, 8'h99, 4'h8, 3'b001, 0, "R12");
    cyc(S_IND | S_STP, 12'h000, 8'h33, 4'h0, 3'b001, 0, "R12");
    cyc(S_SKP | S_IND, 12'h000, 8'h44, 4'h0, 3'b001, 0, "R12");
    // Mixed pseudo-random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] s;
      for (int b = 0; b < 7; b++) s[b] = ($urandom_range(4) == 0);
      cyc(s, 12'($urandom), 8'($urandom), 4'($urandom), 3'($urandom), 1'($urandom),
          tag_of(s));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule